// File: doc/BRIEF.md
# Linear-Count LCD Timing Generator

This block drives a parallel LCD panel with horizontal sync, vertical sync and a data-enable strobe. It also selects the colour placed on the pixel bus. It keeps no line counter. Vertical timing comes from one counter of pixel clocks since the start of the frame. The vertical pulse length and the vertical display window are therefore programmed as frame-linear pixel counts. The horizontal position is kept in a second counter that restarts every horizontal period and is forced back to zero at each frame start.

Software computes every programmed value from a display mode. For a mode with `htotal`, `hdisplay`, `hsync_start`, `hsync_end`, `vtotal`, `vdisplay`, `vsync_start`, `vsync_end` and a skew:

- The horizontal period is `htotal` and the horizontal pulse is `hsync_end - hsync_start`.
- The horizontal window runs from `htotal - hsync_start` to `htotal - (hsync_start - hdisplay) - 1`.
- The frame period is `vtotal * htotal` and the vertical pulse is `(vsync_end - vsync_start) * htotal`.
- The vertical window runs from `(vtotal - vsync_start) * htotal + skew` to `period - (vsync_start - vdisplay) * htotal + skew - 1`.

The upstream pixel source reports on `src_valid` whether its pixel is valid. A missing pixel inside the window is an underflow. The enable is sampled only at frame boundaries. `frame_start` tells software when a new enable value has taken hold.

Top module: `lcd_lin_timing`

## Requirements
- R1: While the generator is idle (after reset, or once a cleared enable has latched), de and frame_start are 0, both syncs sit at their inactive level, and pix_out equals border_color.
- R2: While running, the horizontal sync is active for the first h_pulse clocks of each line. A line is h_period clocks long, and the line position is the frame position modulo h_period.
- R3: While running, the vertical sync is active for the first v_pulse_len clocks of each frame, and every frame lasts exactly v_period clocks.
- R4: de is 1 exactly when the line position lies in the inclusive range [h_disp_start, h_disp_end] and the frame position lies in the inclusive range [v_disp_start, v_disp_end]. A frame therefore carries hdisplay*vdisplay de clocks.
- R5: The sync outputs are active-high when their flag is 0. hsync_low=1 makes hsync active-low, and vsync_low=1 makes vsync active-low.
- R6: pix_out is chosen as follows:
  - outside de, it is border_color;
  - inside de with src_valid=1, it is src_pixel;
  - inside de with src_valid=0 and underflow_recover=1, it is fill_color;
  - inside de with src_valid=0 and underflow_recover=0, it is border_color.
- R7: From idle, an enable of 1 sampled at a clock edge starts a frame at frame position 0 in the very next cycle.
- R8: While running, the enable is sampled only on the last clock of a frame. Clearing it mid-frame lets the frame finish with all its de clocks. Setting it again before that last clock keeps frames running without a gap.
- R9: frame_start is 1 for the single clock at frame position 0 of each running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Requested run state, latched at frame boundaries |
| h_period | input | LW | Clocks per line |
| h_pulse | input | LW | Horizontal sync width in clocks |
| h_disp_start | input | LW | First line position with display data |
| h_disp_end | input | LW | Last line position with display data |
| v_period | input | CW | Clocks per frame |
| v_pulse_len | input | CW | Vertical sync width in clocks |
| v_disp_start | input | CW | First frame position of the vertical window |
| v_disp_end | input | CW | Last frame position of the vertical window |
| hsync_low | input | 1 | 1 selects active-low hsync |
| vsync_low | input | 1 | 1 selects active-low vsync |
| underflow_recover | input | 1 | 1 replaces missing pixels with fill_color |
| border_color | input | PW | Colour outside the display window |
| fill_color | input | PW | Colour used for underflowed pixels |
| src_valid | input | 1 | Upstream pixel is valid this clock |
| src_pixel | input | PW | Upstream pixel value |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display data enable |
| pix_out | output | PW | Pixel bus |
| frame_start | output | 1 | One-clock pulse at frame position 0 |

## Verification
The bound checker watches every cycle for these properties:
- an idle generator stays quiet;
- de never overlaps either sync pulse when the windows sit after the pulses;
- frame_start is always a single clock and always falls inside the vertical pulse;
- the border colour is on the bus whenever de is low.

Several behaviours can only be shown by the bench's scenarios. These are the exact frame length, the per-frame de count, the deferral of a cleared enable to the frame end, and a quick re-enable that leaves no gap. The bench shows them by comparing against a behavioural model on every clock, under two modes, both sync polarities, and random underflow patterns.

// File: rtl/lcd_lin_timing.sv
module lcd_lin_timing #(
  parameter int LW = 12,
  parameter int CW = 22,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [LW-1:0] h_period,
  input  logic [LW-1:0] h_pulse,
  input  logic [LW-1:0] h_disp_start,
  input  logic [LW-1:0] h_disp_end,
  input  logic [CW-1:0] v_period,
  input  logic [CW-1:0] v_pulse_len,
  input  logic [CW-1:0] v_disp_start,
  input  logic [CW-1:0] v_disp_end,
  input  logic          hsync_low,
  input  logic          vsync_low,
  input  logic          underflow_recover,
  input  logic [PW-1:0] border_color,
  input  logic [PW-1:0] fill_color,
  input  logic          src_valid,
  input  logic [PW-1:0] src_pixel,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [PW-1:0] pix_out,
  output logic          frame_start
);

  logic          run_q;
  logic [CW-1:0] fpos;
  logic [LW-1:0] hpos;

  logic frame_end, line_end, restart;
  assign frame_end = (fpos == v_period - CW'(1));
  assign line_end  = (hpos == h_period - LW'(1));
  assign restart   = !run_q || frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      fpos  <= '0;
      hpos  <= '0;
    end else if (restart) begin
      run_q <= enable;
      fpos  <= '0;
      hpos  <= '0;
    end else begin
      fpos <= fpos + CW'(1);
      hpos <= line_end ? '0 : hpos + LW'(1);
    end
  end

  logic h_on, v_on, h_win, v_win;
  assign h_on  = run_q && (hpos < h_pulse);
  assign v_on  = run_q && (fpos < v_pulse_len);
  assign h_win = (hpos >= h_disp_start) && (hpos <= h_disp_end);
  assign v_win = (fpos >= v_disp_start) && (fpos <= v_disp_end);

  assign de          = run_q && h_win && v_win;
  assign hsync       = h_on ^ hsync_low;
  assign vsync       = v_on ^ vsync_low;
  assign frame_start = run_q && (fpos == '0);

  assign pix_out = !de               ? border_color :
                   src_valid         ? src_pixel    :
                   underflow_recover ? fill_color   : border_color;

endmodule

// File: rtl/lcd_lin_timing_chk.sv
module lcd_lin_timing_chk #(
  parameter int LW = 12,
  parameter int CW = 22,
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_q,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          frame_start,
  input logic [PW-1:0] pix_out,
  input logic [PW-1:0] border_color,
  input logic          hsync_low,
  input logic          vsync_low,
  input logic [LW-1:0] h_pulse,
  input logic [LW-1:0] h_disp_start,
  input logic [CW-1:0] v_period,
  input logic [CW-1:0] v_pulse_len,
  input logic [CW-1:0] v_disp_start
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!de && !frame_start && hsync == hsync_low && vsync == vsync_low));

  p_de_outside_hsync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (de && h_disp_start >= h_pulse) |-> (hsync == hsync_low));

  p_de_outside_vsync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (de && v_disp_start >= v_pulse_len) |-> (vsync == vsync_low));

  p_start_in_vsync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && v_pulse_len != '0) |-> (vsync != vsync_low));

  p_border_when_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (pix_out == border_color));

  p_start_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && v_period > CW'(1)) |=> !frame_start);

endmodule

bind lcd_lin_timing lcd_lin_timing_chk #(.LW(LW), .CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .hsync(hsync), .vsync(vsync),
  .de(de), .frame_start(frame_start), .pix_out(pix_out),
  .border_color(border_color), .hsync_low(hsync_low), .vsync_low(vsync_low),
  .h_pulse(h_pulse), .h_disp_start(h_disp_start), .v_period(v_period),
  .v_pulse_len(v_pulse_len), .v_disp_start(v_disp_start)
);

// File: tb/tb_lcd_lin_timing.sv
module tb_lcd_lin_timing;
  localparam int CLK_P = 10;
  localparam int LW = 12, CW = 22, PW = 24;

  logic clk = 0, rst_n = 0, enable = 0;
  logic [LW-1:0] h_period, h_pulse, h_disp_start, h_disp_end;
  logic [CW-1:0] v_period, v_pulse_len, v_disp_start, v_disp_end;
  logic hsync_low = 0, vsync_low = 0, underflow_recover = 1, src_valid = 1;
  logic [PW-1:0] border_color = 24'h112233, fill_color = 24'h0000ff, src_pixel = 24'habcdef;
  logic hsync, vsync, de, frame_start;
  logic [PW-1:0] pix_out;

  lcd_lin_timing #(.LW(LW), .CW(CW), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .h_period(h_period), .h_pulse(h_pulse), .h_disp_start(h_disp_start), .h_disp_end(h_disp_end),
    .v_period(v_period), .v_pulse_len(v_pulse_len), .v_disp_start(v_disp_start), .v_disp_end(v_disp_end),
    .hsync_low(hsync_low), .vsync_low(vsync_low), .underflow_recover(underflow_recover),
    .border_color(border_color), .fill_color(fill_color), .src_valid(src_valid), .src_pixel(src_pixel),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out), .frame_start(frame_start)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int exp_de_frame = 0, exp_len = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_mode(input int ht, hd, hss, hse, vt, vd, vss, vse, skew);
    h_period     = LW'(ht);
    h_pulse      = LW'(hse - hss);
    h_disp_start = LW'(ht - hss);
    h_disp_end   = LW'(ht - (hss - hd) - 1);
    v_period     = CW'(vt * ht);
    v_pulse_len  = CW'((vse - vss) * ht);
    v_disp_start = CW'((vt - vss) * ht + skew);
    v_disp_end   = CW'(vt * ht - (vss - vd) * ht + skew - 1);
    exp_de_frame = hd * vd;
    exp_len      = vt * ht;
  endtask

  // behavioural reference: run flag and linear frame position
  bit m_run = 0;
  int m_f = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_f = 0;
    end else if (!m_run || m_f == int'(v_period) - 1) begin
      m_run = enable; m_f = 0;
    end else begin
      m_f = m_f + 1;
    end
  end

  bit meas_ok = 0;
  int meas_len = 0, meas_de = 0;

  always @(negedge clk) begin
    #3;
    begin
      int line;
      bit e_h, e_v, e_de, e_fs;
      logic [PW-1:0] e_pix;
      line  = m_f % int'(h_period);
      e_h   = m_run && line < int'(h_pulse);
      e_v   = m_run && m_f < int'(v_pulse_len);
      e_de  = m_run && line >= int'(h_disp_start) && line <= int'(h_disp_end)
                    && m_f >= int'(v_disp_start) && m_f <= int'(v_disp_end);
      e_fs  = m_run && m_f == 0;
      e_pix = !e_de ? border_color : src_valid ? src_pixel :
              underflow_recover ? fill_color : border_color;
      chk(hsync == (e_h ^ hsync_low), "R2/R5 hsync", hsync, e_h ^ hsync_low);
      chk(vsync == (e_v ^ vsync_low), "R3/R5 vsync", vsync, e_v ^ vsync_low);
      chk(de == e_de, "R4 de", de, e_de);
      chk(pix_out == e_pix, "R6 pix_out", pix_out, e_pix);
      chk(frame_start == e_fs, "R9 frame_start", frame_start, e_fs);
      if (!m_run) meas_ok = 0;
      else if (frame_start) begin
        if (meas_ok) begin
          chk(meas_len == exp_len, "R3 frame length", meas_len, exp_len);
          chk(meas_de == exp_de_frame, "R4 de per frame", meas_de, exp_de_frame);
        end
        meas_ok = 1; meas_len = 0; meas_de = 0;
      end
      meas_len++;
      if (de) meas_de++;
    end
  end

  task automatic run_random(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      src_valid = ($urandom % 4) != 0;
      src_pixel = PW'($urandom);
    end
  endtask

  task automatic wait_pos(input int f);
    @(negedge clk);
    while (!(m_run && m_f == f)) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 50000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    set_mode(10, 6, 7, 8, 8, 5, 6, 7, 0);
    repeat (4) @(negedge clk);
    #3;
    chk(!hsync && !vsync && !de && !frame_start && pix_out == border_color,
        "R1 reset state", {hsync, vsync, de, frame_start}, 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    enable = 1;
    @(negedge clk); #3;
    chk(frame_start == 1, "R7 start latency", frame_start, 1);
    run_random(260);

    // R8: clear mid-frame, frame must complete with all its de clocks
    wait_pos(10);
    enable = 0; cnt = 0;
    do begin #3; if (de) cnt++; @(negedge clk); end while (m_run);
    chk(cnt == exp_de_frame, "R8 frame completes after clear", cnt, exp_de_frame);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin #3; if (de || frame_start) cnt++; @(negedge clk); end
    chk(cnt == 0, "R1 idle after latched clear", cnt, 0);

    // second mode, active-low syncs, no underflow recovery
    hsync_low = 1; vsync_low = 1; underflow_recover = 0;
    set_mode(16, 10, 12, 14, 6, 3, 4, 5, 0);
    @(negedge clk); #3;
    chk(hsync == 1 && vsync == 1, "R5 idle inactive low-polarity", {hsync, vsync}, 2'b11);
    enable = 1;
    @(negedge clk); #3;
    chk(frame_start == 1, "R7 restart latency", frame_start, 1);
    run_random(300);

    // R8: quick re-enable before the boundary keeps frames continuous
    wait_pos(40);
    enable = 0;
    repeat (5) @(negedge clk);
    enable = 1;
    cnt = 0;
    for (int i = 0; i < 2 * exp_len; i++) begin #3; if (frame_start) cnt++; @(negedge clk); end
    chk(cnt == 2, "R8 no gap on fast re-enable", cnt, 2);
    underflow_recover = 1;
    run_random(250);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule